// File: doc/BRIEF.md
# MDIO Management Master with Register Interface

This block lets software reach the management registers of Ethernet PHYs over the two-wire MDC/MDIO bus using the standard 802.3 Clause 22 frame. Software talks to it through a small 32-bit register window. It first loads a target PHY address and register number. A write frame goes out as soon as the 16-bit data word is stored. A read frame starts when the read-command bit goes from 0 to 1. Software then polls an indicator word until the busy and not-valid flags are both low, and picks up the returned data.

Each frame is 64 MDC periods long, MSB first:
- 32 ones of preamble.
- Start `01`.
- Opcode `01` for a write or `10` for a read.
- 5-bit PHY address, then 5-bit register number.
- A two-bit turnaround.
- 16 data bits.

MDC comes from the system clock through a selectable divider. The largest setting divides by 112. MDIO output bits change on the system clock edge where MDC falls. Read data is sampled on the edge where MDC rises. Outside a frame, MDC sits low and the MDIO driver is off.

A configuration word gives a one-shot abort of the interface. A separate word holds the 5-bit address given to the internal ten-bit-interface PHY, so that it stays clear of the external PHYs.

Top module: `mdio_mgmt_master`

## Requirements
- R1: Word index 2 (ADDR) keeps the PHY address in bits 12:8 and the register number in bits 4:0. Word 6 (TBI) keeps a 5-bit address in bits 4:0 and resets to 0x1F. Word 0 (CFG) keeps the clock select in bits 2:0, which resets to 7. Unused bits read as 0.
- R2: A bus write to word 3 (WDATA) while idle launches a write frame carrying bits 15:0. The frame is 32 ones, `01`, `01`, PHY address, register number, `10`, data. It is driven on MDIO for all 64 bit periods.
- R3: A read frame starts only when a write to word 1 (CMD) changes bit 0 from 0 to 1. Writing 1 while the bit already holds 1 starts nothing.
- R4: Busy, at bit 0 of word 5 (IND), is high for exactly 64 × divisor system-clock cycles, counted from the cycle after the launching write.
- R5: Not-valid, at bit 2 of IND, goes high when a read launches. It stays high until the read data is captured, and it clears on the same cycle as busy.
- R6: A read frame drives MDIO only for its first 46 bits (preamble through register number). It samples the last 16 bits on MDC rising edges, MSB first, and returns them in bits 15:0 of word 4 (RDATA).
- R7: Writing CFG with bit 31 set aborts any frame. On the next cycle busy, not-valid, MDC and the MDIO enable are all low. Bit 31 reads back 0, and the clock-select field takes the written value.
- R8: Clock select values 0..7 pick MDC divisors 4, 8, 16, 32, 64, 80, 96 and 112 of the system clock.
- R9: While a frame runs, writes to WDATA and 0-to-1 changes of the CMD bit launch nothing. The running frame finishes unchanged.
- R10: When idle, MDC is low and the MDIO output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i (combinational) |
| mdc_o | output | 1 | Management clock |
| mdio_i | input | 1 | MDIO pad input |
| mdio_o | output | 1 | MDIO pad output value |
| mdio_oe_o | output | 1 | MDIO pad output enable |

## Verification
The bench attacks the read handshake: it rewrites a CMD bit that already holds 1 and expects no frame. A design that launches on the level of the bit rather than its rising edge would start a stray read here. It also issues launches in the middle of a running frame. A design without the busy gate would corrupt the bits a PHY model captures on MDC.

An abort part-way through a read must leave MDC low and not-valid clear on the next cycle. A design that lets the clock divider run one more cycle would show an MDC pulse there. Timing of busy at divisors 4, 8, 16 and 112 catches any off-by-one in the divider. The turnaround release point catches a read that keeps driving into the PHY's data bits.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_W  = 64;
  localparam int DATA_W   = 16;
  localparam int ADR_W    = 5;
  localparam int DRIVE_RD = 46;
  localparam int CNT_W    = 7;
  localparam int SEL_W    = 3;

  typedef enum logic [2:0] {
    RA_CFG   = 3'd0,
    RA_CMD   = 3'd1,
    RA_ADDR  = 3'd2,
    RA_WDATA = 3'd3,
    RA_RDATA = 3'd4,
    RA_IND   = 3'd5,
    RA_TBI   = 3'd6,
    RA_NONE  = 3'd7
  } reg_idx_e;

  function automatic logic [CNT_W-1:0] div_of(input logic [SEL_W-1:0] sel);
    case (sel)
      3'd0:    return CNT_W'(4);
      3'd1:    return CNT_W'(8);
      3'd2:    return CNT_W'(16);
      3'd3:    return CNT_W'(32);
      3'd4:    return CNT_W'(64);
      3'd5:    return CNT_W'(80);
      3'd6:    return CNT_W'(96);
      default: return CNT_W'(112);
    endcase
  endfunction

  function automatic logic [FRAME_W-1:0] build_frame(input logic rd,
                                                     input logic [ADR_W-1:0] phy,
                                                     input logic [ADR_W-1:0] regn,
                                                     input logic [DATA_W-1:0] data);
    return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, regn, 2'b10, data};
  endfunction
endpackage

// File: rtl/mdio_clk_gen.sv
module mdio_clk_gen
  import mdio_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CNT_W-1:0] div_i,
  output logic             mdc_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic [CNT_W-1:0] cnt_q, div_q, half_m1, div_m1;
  logic             mdc_q;

  assign half_m1 = (div_q >> 1) - CNT_W'(1);
  assign div_m1  = div_q - CNT_W'(1);
  assign rise_o  = en_i && (cnt_q == half_m1);
  assign fall_o  = en_i && (cnt_q == div_m1);
  assign mdc_o   = mdc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      div_q <= CNT_W'(112);
      mdc_q <= 1'b0;
    end else if (!en_i) begin
      // divisor is frozen for the whole frame
      cnt_q <= '0;
      div_q <= div_i;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= fall_o ? '0 : cnt_q + CNT_W'(1);
      if (rise_o) mdc_q <= 1'b1;
      if (fall_o) mdc_q <= 1'b0;
    end
  end

  AST_MDC_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !mdc_o); // R10
  AST_MDC_RISE_IN_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mdc_o) |-> $past(en_i)); // R8
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              abort_i,
  input  logic              start_wr_i,
  input  logic              start_rd_i,
  input  logic [ADR_W-1:0]  phy_i,
  input  logic [ADR_W-1:0]  reg_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              mdio_i,
  output logic              busy_o,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  output logic              rd_done_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int IDX_W = $clog2(FRAME_W);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_W - 1);
  localparam logic [IDX_W-1:0] DATA_IDX = IDX_W'(FRAME_W - DATA_W);
  localparam logic [IDX_W-1:0] REL_IDX  = IDX_W'(DRIVE_RD);

  logic [FRAME_W-1:0] sh_q;
  logic [IDX_W-1:0]   idx_q;
  logic               busy_q, is_rd_q;
  logic [DATA_W-1:0]  rd_sh_q, rdata_q;
  logic               last;

  assign last      = (idx_q == LAST_IDX);
  assign busy_o    = busy_q;
  assign mdio_oe_o = busy_q && (!is_rd_q || (idx_q < REL_IDX));
  assign mdio_o    = busy_q && sh_q[FRAME_W-1];
  assign rd_done_o = busy_q && is_rd_q && fall_i && last && !abort_i;
  assign rdata_o   = rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q    <= '0;
      idx_q   <= '0;
      busy_q  <= 1'b0;
      is_rd_q <= 1'b0;
      rd_sh_q <= '0;
      rdata_q <= '0;
    end else if (abort_i) begin
      busy_q  <= 1'b0;
      is_rd_q <= 1'b0;
      idx_q   <= '0;
    end else if (!busy_q) begin
      if (start_wr_i || start_rd_i) begin
        busy_q  <= 1'b1;
        is_rd_q <= start_rd_i;
        idx_q   <= '0;
        sh_q    <= build_frame(start_rd_i, phy_i, reg_i, wdata_i);
      end
    end else begin
      if (rise_i && is_rd_q && (idx_q >= DATA_IDX))
        rd_sh_q <= {rd_sh_q[DATA_W-2:0], mdio_i};
      if (fall_i) begin
        if (last) begin
          busy_q <= 1'b0;
          if (is_rd_q) rdata_q <= rd_sh_q;
        end else begin
          idx_q <= idx_q + IDX_W'(1);
          sh_q  <= sh_q << 1;
        end
      end
    end
  end

  AST_BUSY_ENDS_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> ($past(abort_i) || $past(fall_i))); // R4
  AST_RD_DONE_CLEARS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_done_o |=> !busy_o); // R5
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
  import mdio_pkg::*;
#(
  parameter logic [ADR_W-1:0] TBI_RST = 5'h1F
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              busy_i,
  input  logic              rd_done_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [SEL_W-1:0]  clk_sel_o,
  output logic [ADR_W-1:0]  phy_o,
  output logic [ADR_W-1:0]  reg_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              start_wr_o,
  output logic              start_rd_o,
  output logic              abort_o
);
  reg_idx_e          idx;
  logic [SEL_W-1:0]  sel_q;
  logic              cmd_q, nv_q;
  logic [ADR_W-1:0]  phy_q, regn_q, tbi_q;
  logic [DATA_W-1:0] wdata_q;
  logic              wr_cfg, wr_cmd, wr_adr, wr_dat, wr_tbi;

  assign idx    = reg_idx_e'(reg_addr_i);
  assign wr_cfg = reg_wr_i && (idx == RA_CFG);
  assign wr_cmd = reg_wr_i && (idx == RA_CMD);
  assign wr_adr = reg_wr_i && (idx == RA_ADDR);
  assign wr_dat = reg_wr_i && (idx == RA_WDATA);
  assign wr_tbi = reg_wr_i && (idx == RA_TBI);

  assign abort_o    = wr_cfg && reg_wdata_i[31];
  assign start_wr_o = wr_dat && !busy_i;
  assign start_rd_o = wr_cmd && reg_wdata_i[0] && !cmd_q && !busy_i;

  assign clk_sel_o = sel_q;
  assign phy_o     = phy_q;
  assign reg_o     = regn_q;
  assign wdata_o   = reg_wdata_i[DATA_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q   <= '1;
      cmd_q   <= 1'b0;
      nv_q    <= 1'b0;
      phy_q   <= '0;
      regn_q  <= '0;
      tbi_q   <= TBI_RST;
      wdata_q <= '0;
    end else begin
      if (wr_cfg) sel_q <= reg_wdata_i[SEL_W-1:0];
      if (wr_cmd) cmd_q <= reg_wdata_i[0];
      if (wr_adr) begin
        phy_q  <= reg_wdata_i[8 +: ADR_W];
        regn_q <= reg_wdata_i[0 +: ADR_W];
      end
      if (wr_tbi) tbi_q <= reg_wdata_i[ADR_W-1:0];
      if (wr_dat) wdata_q <= reg_wdata_i[DATA_W-1:0];
      if (abort_o || rd_done_i) nv_q <= 1'b0;
      else if (start_rd_o)      nv_q <= 1'b1;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    case (idx)
      RA_CFG:   reg_rdata_o[SEL_W-1:0]  = sel_q;
      RA_CMD:   reg_rdata_o[0]          = cmd_q;
      RA_ADDR:  begin
        reg_rdata_o[8 +: ADR_W] = phy_q;
        reg_rdata_o[0 +: ADR_W] = regn_q;
      end
      RA_WDATA: reg_rdata_o[DATA_W-1:0] = wdata_q;
      RA_RDATA: reg_rdata_o[DATA_W-1:0] = rdata_i;
      RA_IND:   begin
        reg_rdata_o[0] = busy_i;
        reg_rdata_o[2] = nv_q;
      end
      RA_TBI:   reg_rdata_o[ADR_W-1:0]  = tbi_q;
      default:  reg_rdata_o = '0;
    endcase
  end

  AST_NV_ON_READ_LAUNCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_rd_o |=> (nv_q && busy_i)); // R5
  AST_WRITE_LAUNCH_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_wr_o |=> (busy_i && !nv_q)); // R2
  AST_ABORT_IDLES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |=> (!busy_i && !nv_q)); // R7
  AST_NV_NEEDS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nv_q |-> busy_i); // R5
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_pkg::*;
#(
  parameter logic [4:0] TBI_RST = 5'h1F
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_wr_i,
  input  logic [2:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        mdc_o,
  input  logic        mdio_i,
  output logic        mdio_o,
  output logic        mdio_oe_o
);
  logic [SEL_W-1:0]  clk_sel;
  logic [ADR_W-1:0]  phy, regn;
  logic [DATA_W-1:0] wdata, rdata;
  logic              start_wr, start_rd, abort, busy, rd_done;
  logic              rise, fall, clk_en;

  assign clk_en = busy && !abort;

  mdio_regs #(.TBI_RST(TBI_RST)) u_regs (
    .clk_i, .rst_ni, .reg_wr_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .busy_i(busy), .rd_done_i(rd_done), .rdata_i(rdata),
    .clk_sel_o(clk_sel), .phy_o(phy), .reg_o(regn), .wdata_o(wdata),
    .start_wr_o(start_wr), .start_rd_o(start_rd), .abort_o(abort)
  );

  mdio_clk_gen u_clk (
    .clk_i, .rst_ni, .en_i(clk_en), .div_i(div_of(clk_sel)),
    .mdc_o, .rise_o(rise), .fall_o(fall)
  );

  mdio_frame_seq u_seq (
    .clk_i, .rst_ni, .abort_i(abort), .start_wr_i(start_wr), .start_rd_i(start_rd),
    .phy_i(phy), .reg_i(regn), .wdata_i(wdata), .rise_i(rise), .fall_i(fall),
    .mdio_i, .busy_o(busy), .mdio_o, .mdio_oe_o, .rd_done_o(rd_done), .rdata_o(rdata)
  );

  AST_MDC_ONLY_WHEN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mdc_o) |-> busy); // R10
endmodule

// File: tb/mdio_mgmt_master_tb_top.sv
`timescale 1ns/1ps
module mdio_mgmt_master_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        mdc, mdio_in, mdio_out, mdio_oe;

  int          checks = 0;
  int          errors = 0;
  logic [63:0] cap = '0;
  int          nbits = 0;
  int          oe_bits = 0;
  logic [15:0] phy_data = '0;

  always #4 clk = ~clk;

  mdio_mgmt_master dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .mdc_o(mdc), .mdio_i(mdio_in),
    .mdio_o(mdio_out), .mdio_oe_o(mdio_oe)
  );

  // PHY model: captures what the master drives, returns data after turnaround
  always @(posedge mdc) begin
    cap = {cap[62:0], mdio_out & mdio_oe};
    if (mdio_oe) oe_bits++;
    nbits++;
  end

  function automatic logic phy_bit(input int n, input logic [15:0] d);
    if (n >= 48 && n < 64) return d[63 - n];
    return 1'b1;
  endfunction
  assign mdio_in = mdio_oe ? mdio_out : phy_bit(nbits, phy_data);

  function automatic logic [63:0] exp_frame(input logic rd, input logic [4:0] p,
                                            input logic [4:0] r, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), p, r, 2'b10, d};
  endfunction

  function automatic int div_exp(input int sel);
    case (sel)
      0: return 4;   1: return 8;   2: return 16;  3: return 32;
      4: return 64;  5: return 80;  6: return 96;  default: return 112;
    endcase
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic wait_idle(output int cyc);
    logic [31:0] v;
    cyc = 0;
    bus_rd(3'd5, v);
    while (v[0] && cyc < 20000) begin
      cyc++;
      @(negedge clk);
      bus_rd(3'd5, v);
    end
  endtask

  task automatic run_frame(input logic rd, input logic [4:0] p, input logic [4:0] r,
                           input logic [15:0] d, input int sel);
    logic [31:0] v;
    logic [63:0] ef;
    int cyc;
    phy_data = d;
    bus_wr(3'd2, {19'd0, p, 3'd0, r});
    cap = '0; nbits = 0; oe_bits = 0;
    if (rd) begin
      bus_wr(3'd1, 32'd0);
      bus_wr(3'd1, 32'd1);
    end else begin
      bus_wr(3'd3, {16'd0, d});
    end
    bus_rd(3'd5, v);
    check("R5 not-valid at launch", {63'd0, v[2]}, {63'd0, rd});
    wait_idle(cyc);
    check("R4 busy length", cyc, 64 * div_exp(sel));
    ef = exp_frame(rd, p, r, d);
    bus_rd(3'd5, v);
    check("R5 flags clear after frame", v, 32'd0);
    if (rd) begin
      check("R6 driven read header", cap[63:18], ef[63:18]);
      check("R6 driven bit count", oe_bits, 46);
      bus_rd(3'd4, v);
      check("R6 read data", v, {16'd0, d});
    end else begin
      check("R2 write frame", cap, ef);
      check("R2 driven bit count", oe_bits, 64);
    end
    check("R10 idle mdc/oe", {mdc, mdio_oe}, 2'b00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int cyc;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    bus_rd(3'd5, v); check("R10 reset indicator", v, 32'd0);
    bus_rd(3'd0, v); check("R1 reset clock select", v, 32'd7);
    bus_rd(3'd6, v); check("R1 reset tbi address", v, 32'h1F);
    check("R10 reset pins", {mdc, mdio_oe}, 2'b00);

    // register fields
    bus_wr(3'd2, 32'hFFFF_FFFF);
    bus_rd(3'd2, v); check("R1 address fields", v, 32'h0000_1F1F);
    bus_wr(3'd6, 32'hFFFF_FFE3);
    bus_rd(3'd6, v); check("R1 tbi field", v, 32'h3);

    // divide-by-112 write at reset select
    run_frame(1'b0, 5'h11, 5'h04, 16'hA5C3, 7);

    // divide-by-4 read
    bus_wr(3'd0, 32'd0);
    run_frame(1'b1, 5'h01, 5'h02, 16'h8001, 0);

    // R3: CMD already 1, writing 1 again launches nothing
    bus_wr(3'd1, 32'd1);
    bus_rd(3'd5, v); check("R3 no launch on held bit", v[0], 1'b0);

    // R9: launches during a running write frame are ignored
    bus_wr(3'd2, {19'd0, 5'h0A, 3'd0, 5'h1B});
    cap = '0; nbits = 0; oe_bits = 0;
    bus_wr(3'd3, 32'h0000_1234);
    bus_wr(3'd3, 32'h0000_FFFF);
    bus_wr(3'd1, 32'd0);
    bus_wr(3'd1, 32'd1);
    bus_rd(3'd5, v); check("R9 no not-valid from busy read", v[2], 1'b0);
    wait_idle(cyc);
    check("R9 frame unchanged", cap, exp_frame(1'b0, 5'h0A, 5'h1B, 16'h1234));
    bus_rd(3'd5, v); check("R9 idle after frame", v, 32'd0);

    // R7: abort in the middle of a read at divide-by-8
    bus_wr(3'd0, 32'd1);
    bus_wr(3'd1, 32'd0);
    bus_wr(3'd1, 32'd1);
    repeat (150) @(negedge clk);
    bus_rd(3'd5, v); check("R7 busy before abort", v, 32'h5);
    bus_wr(3'd0, 32'h8000_0002);
    bus_rd(3'd5, v); check("R7 flags after abort", v, 32'd0);
    check("R7 pins after abort", {mdc, mdio_oe}, 2'b00);
    bus_rd(3'd0, v); check("R7 cfg readback", v, 32'd2);
    repeat (40) @(negedge clk);
    check("R7 mdc stays low", {mdc, mdio_oe}, 2'b00);

    // R8: random frames across divisors
    for (int i = 0; i < 16; i++) begin
      int sel;
      logic rd;
      sel = $urandom_range(0, 2);
      rd  = 1'($urandom_range(0, 1));
      bus_wr(3'd0, 32'(sel));
      run_frame(rd, 5'($urandom), 5'($urandom), 16'($urandom), sel);
    end

    // R6 corner: all-zero and all-one read data
    bus_wr(3'd0, 32'd0);
    run_frame(1'b1, 5'h1F, 5'h1F, 16'h0000, 0);
    run_frame(1'b1, 5'h00, 5'h00, 16'hFFFF, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule